// File: doc/BRIEF.md
# CAS Change Debounce Reporter

The block follows the 4-bit channel-associated signaling (CAS) nibble of every channel on up to eight TDM lines, each with up to thirty-two channels. Two nibbles are followed per channel: the transmit nibble, which comes from the TDM signaling input, and the receive nibble, which comes from arriving cells. Upstream logic presents each channel once per multiframe through a sample strobe. The strobe carries a line index, a channel index and both nibbles.

For each channel the block keeps three items: the last value it reported, a candidate value, and a pending flag. A new value differs from the reported one only in the CAS bits that the channel's compare mask enables. Such a value becomes the candidate. If the next sample of that channel matches the candidate, the change is confirmed. Only this single internal debounce is done; any further filtering is left to software.

A confirmed change writes a 16-bit event word into a 16-entry FIFO. The word holds the line, the channel and the full unmasked nibbles. A processor pops words by reading the data port. A level flag shows that the FIFO holds unread words, and this flag drives an interrupt through an enable bit. Events that find the FIFO full are dropped, and a sticky overflow flag is raised.

Top module: `cas_debounce_reporter`

## Requirements
- R1: After reset the FIFO is empty, `fifo_nempty`, `irq` and `ovf` are 0, `rd_data` is 0, every channel's reported and candidate values are 0 with no change pending, and every compare mask is 8'hFF.
- R2: A sample whose masked value differs from the channel's reported value makes that value the candidate and sets pending. It writes no event.
- R3: A sample of a pending channel whose masked value equals the candidate writes one event word one clock later. The word is laid out as bits 15:13 line, bits 12:8 channel, bits 7:4 receive nibble, bits 3:0 transmit nibble. The sample becomes the reported value and pending clears.
- R4: A pending channel whose next sample returns to the reported value (masked) drops pending and writes no event. A pending channel whose next sample differs from both the candidate and the reported value takes that sample as its new candidate, so confirmation needs one more matching sample.
- R5: A write of `cfg_mask` sets the selected channel's compare mask. Bits 7:4 enable the receive nibble bits 3:0 and bits 3:0 enable the transmit nibble bits 3:0. A change on a disabled bit neither starts nor confirms an event.
- R6: The nibbles in an event word are the full unmasked values of the confirming sample, including bits that are disabled in the mask.
- R7: The FIFO holds 16 words and returns them in the order they were written. A cycle with `rd_en` high and the FIFO not empty removes the head word. `rd_data` shows the head word while the FIFO is not empty.
- R8: While the FIFO is empty, `rd_data` is 0 and a read changes no state.
- R9: An event that arrives while the FIFO holds 16 words is dropped and sets `ovf`. `ovf` stays high until a cycle with `ovf_clr` high. If a new overflow happens in the same cycle as the clear, the set wins.
- R10: `irq` is high exactly when `irq_en` is high and the FIFO is not empty.
- R11: Each line and channel pair keeps its own debounce state. Samples of one channel do not affect the state of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | One-cycle strobe: the channel sample on the next four ports is valid |
| smp_line | input | 3 | Line index of the sample |
| smp_chan | input | 5 | Channel index of the sample |
| smp_tx | input | 4 | Transmit CAS nibble from the TDM side |
| smp_rx | input | 4 | Receive CAS nibble from arriving cells |
| cfg_we | input | 1 | Write strobe for a compare mask |
| cfg_line | input | 3 | Line index of the mask write |
| cfg_chan | input | 5 | Channel index of the mask write |
| cfg_mask | input | 8 | Compare mask: bits 7:4 receive, bits 3:0 transmit, 1 means compared |
| rd_en | input | 1 | Pops the head event word |
| ovf_clr | input | 1 | Clears the overflow flag |
| irq_en | input | 1 | Interrupt enable |
| rd_data | output | 16 | Head event word, or 0 while the FIFO is empty |
| fifo_nempty | output | 1 | FIFO holds at least one unread word |
| ovf | output | 1 | Sticky flag: an event was dropped |
| irq | output | 1 | Interrupt request |

## Verification
The embedded properties are checked on every cycle. They cover four things: the FIFO occupancy never goes past its depth, a read of an empty FIFO leaves the occupancy unchanged, the overflow flag rises after a push into a full FIFO and holds until it is cleared, and a confirmed event always clears the pending flag of its channel. Other behaviour depends on sequences of samples to the same channel and can only be shown by the bench's scenarios. This covers the two-sample confirmation, the revert and restart paths, the effect of the mask on detection and the full nibbles carried in the reported word, the order of words in the FIFO, and the independence of interleaved channels.

// File: rtl/cas_rep_pkg.sv
// Package: shared widths and the event word layout for the CAS reporter.
// Assumes the event format is fixed at 16 bits: 3-bit line, 5-bit channel,
// two 4-bit nibbles.
package cas_rep_pkg;
    localparam int LINE_W = 3;
    localparam int CHAN_W = 5;
    localparam int NIB_W  = 4;
    localparam int VAL_W  = 2 * NIB_W;        // {rx, tx}
    localparam int IDX_W  = LINE_W + CHAN_W;  // flat channel index
    localparam int EVT_W  = IDX_W + VAL_W;

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic [CHAN_W-1:0] chan;
        logic [NIB_W-1:0]  rx;
        logic [NIB_W-1:0]  tx;
    } cas_evt_t;
endpackage

// File: rtl/cas_chan_track.sv
// Module: per-channel CAS debounce state and change decision.
// Holds reported value, candidate value, pending flag and compare mask for
// every channel. Assumes at most one sample per cycle and one sample per
// channel per multiframe. evt_push is combinational from the sample and is
// registered by the FIFO.
module cas_chan_track
    import cas_rep_pkg::*;
#(
    parameter int ENTRIES = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [IDX_W-1:0] smp_idx,
    input  logic [VAL_W-1:0] smp_val,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [VAL_W-1:0] cfg_mask,
    output logic             evt_push,
    output logic [VAL_W-1:0] evt_val
);
    localparam int AW = $clog2(ENTRIES);

    logic [VAL_W-1:0] rep_q  [ENTRIES];
    logic [VAL_W-1:0] cand_q [ENTRIES];
    logic [VAL_W-1:0] mask_q [ENTRIES];
    logic             pend_q [ENTRIES];

    logic [AW-1:0]    idx;
    logic [VAL_W-1:0] msk;
    logic             diff_rep, diff_cand, pend_cur;

    // Decide, for the sampled channel, whether it differs from reported/candidate.
    always_comb begin
        idx       = AW'(smp_idx);
        msk       = mask_q[idx];
        pend_cur  = pend_q[idx];
        diff_rep  = |((smp_val ^ rep_q[idx])  & msk);
        diff_cand = |((smp_val ^ cand_q[idx]) & msk);
        evt_push  = smp_valid && pend_cur && !diff_cand;
        evt_val   = smp_val;
    end

    // Update the debounce state of the sampled channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                rep_q[i]  <= '0;
                cand_q[i] <= '0;
                pend_q[i] <= 1'b0;
            end
        end else if (smp_valid) begin
            if (pend_cur) begin
                if (!diff_cand) begin
                    rep_q[idx]  <= smp_val;
                    pend_q[idx] <= 1'b0;
                end else if (!diff_rep) begin
                    pend_q[idx] <= 1'b0;
                end else begin
                    cand_q[idx] <= smp_val;
                end
            end else if (diff_rep) begin
                cand_q[idx] <= smp_val;
                pend_q[idx] <= 1'b1;
            end
        end
    end

    // Hold the per-channel compare masks written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) mask_q[i] <= '1;
        end else if (cfg_we) begin
            mask_q[AW'(cfg_idx)] <= cfg_mask;
        end
    end

    // A confirmed event leaves its channel with no change pending.
    assert_confirm_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        evt_push |=> !pend_q[$past(idx)]);
endmodule

// File: rtl/cas_evt_fifo.sv
// Module: event FIFO with sticky overflow.
// Assumes DEPTH is a power of two. A push into a full FIFO is dropped, even
// when a pop happens in the same cycle. Read data is 0 while empty.
module cas_evt_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    input  logic         ovf_clr,
    output logic [W-1:0] rd_data,
    output logic         nempty,
    output logic         ovf
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [CW-1:0] count;
    logic          full, do_push, do_pop;

    // Qualify push and pop against the occupancy.
    always_comb begin
        full    = (count == CW'(DEPTH));
        nempty  = (count != '0);
        do_push = push && !full;
        do_pop  = pop && nempty;
        rd_data = nempty ? mem[rptr] : '0;
    end

    // Store accepted words.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // Sticky overflow: set on a dropped push, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)              ovf <= 1'b0;
        else if (push && full)   ovf <= 1'b1;
        else if (ovf_clr)        ovf <= 1'b0;
    end

    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    assert_empty_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !nempty && !push) |=> !nempty);
    assert_overflow_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> ovf);
    assert_overflow_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);
endmodule

// File: rtl/cas_debounce_reporter.sv
// Module: top of the CAS change debounce reporter.
// Joins the per-channel tracker with the event FIFO, packs event words and
// gates the interrupt. Assumes one sample per channel per multiframe.
module cas_debounce_reporter
    import cas_rep_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [LINE_W-1:0] smp_line,
    input  logic [CHAN_W-1:0] smp_chan,
    input  logic [NIB_W-1:0]  smp_tx,
    input  logic [NIB_W-1:0]  smp_rx,
    input  logic              cfg_we,
    input  logic [LINE_W-1:0] cfg_line,
    input  logic [CHAN_W-1:0] cfg_chan,
    input  logic [VAL_W-1:0]  cfg_mask,
    input  logic              rd_en,
    input  logic              ovf_clr,
    input  logic              irq_en,
    output logic [EVT_W-1:0]  rd_data,
    output logic              fifo_nempty,
    output logic              ovf,
    output logic              irq
);
    localparam int ENTRIES = 1 << IDX_W;

    logic             evt_push;
    logic [VAL_W-1:0] evt_val;
    cas_evt_t         evt_word;

    cas_chan_track #(.ENTRIES(ENTRIES)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_valid(smp_valid),
        .smp_idx  ({smp_line, smp_chan}),
        .smp_val  ({smp_rx, smp_tx}),
        .cfg_we   (cfg_we),
        .cfg_idx  ({cfg_line, cfg_chan}),
        .cfg_mask (cfg_mask),
        .evt_push (evt_push),
        .evt_val  (evt_val)
    );

    // Pack the event word from the sample coordinates and confirmed value.
    always_comb begin
        evt_word.line = smp_line;
        evt_word.chan = smp_chan;
        evt_word.rx   = evt_val[VAL_W-1:NIB_W];
        evt_word.tx   = evt_val[NIB_W-1:0];
    end

    cas_evt_fifo #(.DEPTH(FIFO_DEPTH), .W(EVT_W)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (evt_push),
        .push_data(evt_word),
        .pop      (rd_en),
        .ovf_clr  (ovf_clr),
        .rd_data  (rd_data),
        .nempty   (fifo_nempty),
        .ovf      (ovf)
    );

    // Interrupt follows the not-empty level through the enable.
    always_comb irq = fifo_nempty && irq_en;
endmodule

// File: tb/cas_debounce_reporter_test.sv
module cas_debounce_reporter_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0;
    logic [2:0] smp_line = '0;
    logic [4:0] smp_chan = '0;
    logic [3:0] smp_tx = '0, smp_rx = '0;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_line = '0;
    logic [4:0] cfg_chan = '0;
    logic [7:0] cfg_mask = '0;
    logic rd_mon = 1'b0, rd_man = 1'b0;
    logic ovf_clr = 1'b0, irq_en = 1'b0;
    logic [15:0] rd_data;
    logic fifo_nempty, ovf, irq;

    int checks = 0, errors = 0, got = 0;
    bit drain = 1'b1, done = 1'b0;
    string tag = "R1";
    logic [15:0] exp_q[$];

    always #10 clk = ~clk;   // 50 MHz

    cas_debounce_reporter uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_line(smp_line),
        .smp_chan(smp_chan), .smp_tx(smp_tx), .smp_rx(smp_rx), .cfg_we(cfg_we),
        .cfg_line(cfg_line), .cfg_chan(cfg_chan), .cfg_mask(cfg_mask),
        .rd_en(rd_mon | rd_man), .ovf_clr(ovf_clr), .irq_en(irq_en),
        .rd_data(rd_data), .fifo_nempty(fifo_nempty), .ovf(ovf), .irq(irq));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] word(input int ln, input int ch, input int rx, input int tx);
        return {ln[2:0], ch[4:0], rx[3:0], tx[3:0]};
    endfunction

    task automatic sample(input int ln, input int ch, input int tx, input int rx);
        @(negedge clk);
        smp_valid = 1'b1; smp_line = ln[2:0]; smp_chan = ch[4:0];
        smp_tx = tx[3:0]; smp_rx = rx[3:0];
        @(negedge clk);
        smp_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic set_mask(input int ln, input int ch, input int m);
        @(negedge clk);
        cfg_we = 1'b1; cfg_line = ln[2:0]; cfg_chan = ch[4:0]; cfg_mask = m[7:0];
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Monitor: pops every word the design produces and compares with the scoreboard.
    always begin
        @(negedge clk);
        if (rd_mon) rd_mon = 1'b0;
        else if (drain && fifo_nempty && rst_n) begin
            got++;
            if (exp_q.size() == 0) chk(1'b0, {tag, " unexpected event"}, int'(rd_data), 0);
            else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                chk(rd_data == e, tag, int'(rd_data), int'(e));
            end
            rd_mon = 1'b1;
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int g0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(fifo_nempty == 0, "R1 nempty", fifo_nempty, 0);
        chk(irq == 0, "R1 irq", irq, 0);
        chk(ovf == 0, "R1 ovf", ovf, 0);
        chk(rd_data == 0, "R1 rd_data", rd_data, 0);
        irq_en = 1'b1;

        // R1/R2: a sample equal to the reset value is no change; a different one only pends
        tag = "R2";
        sample(0, 5, 0, 0);
        sample(0, 5, 9, 0);
        chk(got == 0, "R2 no event after first change", got, 0);
        // R3: confirming sample produces the word
        tag = "R3";
        exp_q.push_back(word(0, 5, 0, 9));
        sample(0, 5, 9, 0);
        chk(got == 1, "R3 event count", got, 1);
        exp_q.push_back(word(7, 31, 10, 6));
        sample(7, 31, 6, 10);
        sample(7, 31, 6, 10);
        chk(got == 2, "R3 field layout event", got, 2);

        // R4: revert and restart
        tag = "R4";
        sample(0, 1, 3, 0);
        sample(0, 1, 0, 0);
        sample(0, 1, 3, 0);
        chk(got == 2, "R4 revert gives no event", got, 2);
        sample(0, 1, 4, 0);
        chk(got == 2, "R4 restart gives no event", got, 2);
        exp_q.push_back(word(0, 1, 0, 4));
        sample(0, 1, 4, 0);
        chk(got == 3, "R4 restarted change confirmed", got, 3);

        // R11: interleaved channels keep separate state
        tag = "R11";
        sample(3, 10, 1, 0);
        sample(3, 11, 2, 0);
        exp_q.push_back(word(3, 10, 0, 1));
        sample(3, 10, 1, 0);
        exp_q.push_back(word(3, 11, 0, 2));
        sample(3, 11, 2, 0);
        chk(got == 5, "R11 two interleaved events", got, 5);

        // R5/R6: receive bits disabled; transmit change reports full nibbles
        tag = "R5";
        set_mask(2, 3, 8'h0F);
        sample(2, 3, 0, 5);
        sample(2, 3, 0, 5);
        chk(got == 5, "R5 masked rx change ignored", got, 5);
        tag = "R6";
        sample(2, 3, 2, 5);
        exp_q.push_back(word(2, 3, 5, 2));
        sample(2, 3, 2, 5);
        chk(got == 6, "R6 event with unmasked nibbles", got, 6);

        // R10: interrupt gating
        tag = "R10";
        drain = 1'b0;
        exp_q.push_back(word(4, 0, 0, 7));
        sample(4, 0, 7, 0);
        sample(4, 0, 7, 0);
        chk(irq == 1, "R10 irq with entry and enable", irq, 1);
        irq_en = 1'b0;
        #1 chk(irq == 0, "R10 irq masked", irq, 0);
        irq_en = 1'b1;
        drain = 1'b1;
        repeat (4) @(negedge clk);
        chk(irq == 0, "R10 irq low after drain", irq, 0);

        // R8: read of empty FIFO
        tag = "R8";
        drain = 1'b0;
        chk(rd_data == 0, "R8 rd_data zero when empty", rd_data, 0);
        rd_man = 1'b1;
        @(negedge clk);
        rd_man = 1'b0;
        chk(fifo_nempty == 0, "R8 still empty", fifo_nempty, 0);
        exp_q.push_back(word(5, 2, 0, 1));
        sample(5, 2, 1, 0);
        sample(5, 2, 1, 0);
        chk(rd_data == word(5, 2, 0, 1), "R8 next word intact", rd_data, word(5, 2, 0, 1));
        drain = 1'b1;
        repeat (4) @(negedge clk);

        // R9/R7: overflow and ordering
        tag = "R9";
        drain = 1'b0;
        g0 = got;
        for (int c = 0; c < 17; c++) begin
            if (c < 16) exp_q.push_back(word(1, c, 0, 1));
            sample(1, c, 1, 0);
            sample(1, c, 1, 0);
        end
        chk(ovf == 1, "R9 ovf after drop", ovf, 1);
        repeat (3) @(negedge clk);
        chk(ovf == 1, "R9 ovf sticky", ovf, 1);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        chk(ovf == 0, "R9 ovf cleared", ovf, 0);
        tag = "R7";
        drain = 1'b1;
        repeat (40) @(negedge clk);
        chk(got - g0 == 16, "R7 sixteen words in order", got - g0, 16);
        chk(exp_q.size() == 0, "R7 scoreboard empty", exp_q.size(), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule